// File: doc/BRIEF.md
# Incremental PID Control Update

This block is a sampled-data controller that computes the velocity (incremental) form of a PID law. On each sample strobe it takes a setpoint and a measurement, forms their difference, and computes a new control value. That value is the previous control value plus three weighted error terms: the current error, the error one sample back and the error two samples back. The three weights are supplied already computed as signed fixed-point inputs. For a loop gain K, a sample period T, an integral time Ti and a derivative time Td, they would be set as follows:

- current-error weight K(1 + T/Ti + Td/T)
- one-back weight −K(1 + 2Td/T)
- two-back weight K·Td/T

The block keeps only three items of state: the last control value and the two previous errors. There is no separate integrator and no derivative path. The control output is saturated to the output range and then held. It is meant to feed a DAC holding register directly. A one-cycle valid pulse marks each new value.

Top module: `pid_incr_ctrl`

## Requirements
- R1: The error for a sample is ref_i − meas_i. Both are 12-bit two's complement. The difference is formed in 13 bits, so it never wraps (e.g. 2047 − (−2048) = 4095).
- R2: The new output is floor((ctrl_prev·4096 + a·e(k) + b·e(k−1) + c·e(k−2)) / 4096). The sum is computed at full precision, and the fraction is discarded by flooring toward minus infinity.
- R3: coef_a_i, coef_b_i and coef_c_i are 16-bit signed Q4.12: value = code / 4096, so 0x1000 is 1.0 and 0xE000 is −2.0. They weight e(k), e(k−1) and e(k−2) respectively.
- R4: After each update, the one-back error takes the current error and the two-back error takes the old one-back error.
- R5: ctrl_o changes only on an update or a clear. Between these it holds, whatever ref_i and meas_i do.
- R6: The result is saturated to [−2048, 2047]. The saturated value is what is stored and used as ctrl_prev for the next sample.
- R7: clr_i, sampled at a clock edge, sets the stored output and both stored errors to zero. The pipeline is discarded. A strobe in the same cycle as clr_i is ignored.
- R8: valid_o is a one-cycle pulse. If strobe_i is sampled high at edge N, valid_o and the new ctrl_o appear after edge N+2.
- R9: While rst_ni is low, ctrl_o is 0 and valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of output and error history |
| strobe_i | input | 1 | Sample instant, one cycle |
| ref_i | input | 12 | Setpoint, signed |
| meas_i | input | 12 | Measured plant output, signed |
| coef_a_i | input | 16 | Weight of current error, signed Q4.12 |
| coef_b_i | input | 16 | Weight of one-back error, signed Q4.12 |
| coef_c_i | input | 16 | Weight of two-back error, signed Q4.12 |
| ctrl_o | output | 12 | Control output to DAC register, signed |
| valid_o | output | 1 | New ctrl_o available |

## Verification
The assertions assume that strobes are at least three cycles apart, so that a new sample never enters while an update is still in flight. They also assume the weights stay steady across an update. The bench issues each strobe only after the previous result has been checked, so strobes are always four cycles apart, and it changes the weights only between updates. Setpoint and measurement extremes are chosen to drive the full-precision sum past both saturation limits. A negative fractional case exercises the flooring.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int DATA_W = 12;  // ref, meas, ctrl
  localparam int COEF_W = 16;  // Q4.12
  localparam int FRAC_W = 12;
  localparam int NTAP   = 3;   // e(k), e(k-1), e(k-2)
  localparam int LAT    = 3;   // strobe edge to valid edge, inclusive
endpackage

// File: rtl/pid_err_taps.sv
module pid_err_taps #(
  parameter int DATA_W = pid_pkg::DATA_W,
  parameter int NTAP   = pid_pkg::NTAP,
  localparam int ERR_W = DATA_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     smp_i,
  input  logic                     adv_i,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic signed [DATA_W-1:0] meas_i,
  output logic signed [ERR_W-1:0]  err_o [NTAP]
);
  logic signed [ERR_W-1:0] err_q [NTAP];
  logic signed [ERR_W-1:0] diff_w;

  assign diff_w = ERR_W'(ref_i) - ERR_W'(meas_i);

  // slot 0 = current error, higher slots = history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NTAP; i++) err_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < NTAP; i++) err_q[i] <= '0;
    end else begin
      if (smp_i) err_q[0] <= diff_w;
      if (adv_i) begin
        for (int i = 1; i < NTAP; i++) err_q[i] <= err_q[i-1];
      end
    end
  end

  assign err_o = err_q;

  AST_TAP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (err_q[1] == $past(err_q[0]))) else $error("tap shift"); // R4
  AST_TAP_AGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (err_q[NTAP-1] == $past(err_q[NTAP-2]))) else $error("tap age"); // R4
  AST_CLR_TAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_q[1] == '0 && err_q[NTAP-1] == '0)) else $error("clr taps"); // R7
endmodule

// File: rtl/pid_mac.sv
module pid_mac #(
  parameter int DATA_W = pid_pkg::DATA_W,
  parameter int COEF_W = pid_pkg::COEF_W,
  parameter int FRAC_W = pid_pkg::FRAC_W,
  parameter int NTAP   = pid_pkg::NTAP,
  localparam int ERR_W = DATA_W + 1,
  localparam int PRD_W = ERR_W + COEF_W,
  localparam int SUM_W = PRD_W + $clog2(NTAP + 1) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     mul_i,
  input  logic                     acc_i,
  input  logic signed [ERR_W-1:0]  err_i  [NTAP],
  input  logic signed [COEF_W-1:0] coef_i [NTAP],
  output logic signed [DATA_W-1:0] ctrl_o
);
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SUM_W'(2 ** (DATA_W - 1));

  logic signed [PRD_W-1:0]  prd_q [NTAP];
  logic signed [SUM_W-1:0]  sum_w;
  logic signed [SUM_W-1:0]  quo_w;
  logic signed [DATA_W-1:0] ctrl_q;
  logic signed [DATA_W-1:0] ctrl_d;

  for (genvar i = 0; i < NTAP; i++) begin : g_prd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    prd_q[i] <= '0;
      else if (mul_i) prd_q[i] <= PRD_W'(err_i[i]) * PRD_W'(coef_i[i]);
    end
  end

  always_comb begin
    sum_w = SUM_W'(ctrl_q) <<< FRAC_W;
    for (int i = 0; i < NTAP; i++) sum_w = sum_w + SUM_W'(prd_q[i]);
  end

  assign quo_w = sum_w >>> FRAC_W;  // floor

  always_comb begin
    if (quo_w > SAT_HI)      ctrl_d = SAT_HI[DATA_W-1:0];
    else if (quo_w < SAT_LO) ctrl_d = SAT_LO[DATA_W-1:0];
    else                     ctrl_d = quo_w[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (clr_i)   ctrl_q <= '0;
    else if (acc_i)   ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !clr_i) |=> $stable(ctrl_q)) else $error("hold"); // R5
  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i && quo_w > SAT_HI) |=> (ctrl_q == SAT_HI[DATA_W-1:0])) else $error("sat hi"); // R6
  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i && quo_w < SAT_LO) |=> (ctrl_q == SAT_LO[DATA_W-1:0])) else $error("sat lo"); // R6
  AST_CLR_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ctrl_q == '0)) else $error("clr out"); // R7
endmodule

// File: rtl/pid_incr_ctrl.sv
module pid_incr_ctrl #(
  parameter int DATA_W = pid_pkg::DATA_W,
  parameter int COEF_W = pid_pkg::COEF_W,
  parameter int FRAC_W = pid_pkg::FRAC_W,
  localparam int NTAP  = pid_pkg::NTAP,
  localparam int ERR_W = DATA_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     strobe_i,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic signed [DATA_W-1:0] meas_i,
  input  logic signed [COEF_W-1:0] coef_a_i,
  input  logic signed [COEF_W-1:0] coef_b_i,
  input  logic signed [COEF_W-1:0] coef_c_i,
  output logic signed [DATA_W-1:0] ctrl_o,
  output logic                     valid_o
);
  logic                    smp_w;
  logic                    v1_q, v2_q, vld_q;
  logic signed [ERR_W-1:0]  err_w  [NTAP];
  logic signed [COEF_W-1:0] coef_w [NTAP];

  assign smp_w     = strobe_i & ~clr_i;  // clear wins
  assign coef_w[0] = coef_a_i;
  assign coef_w[1] = coef_b_i;
  assign coef_w[2] = coef_c_i;

  // stage 1: error, stage 2: products + tap shift, stage 3: sum + saturate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      v1_q  <= smp_w;
      v2_q  <= v1_q & ~clr_i;
      vld_q <= v2_q & ~clr_i;
    end
  end

  pid_err_taps #(.DATA_W(DATA_W), .NTAP(NTAP)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .smp_i  (smp_w),
    .adv_i  (v1_q),
    .ref_i  (ref_i),
    .meas_i (meas_i),
    .err_o  (err_w)
  );

  pid_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .NTAP(NTAP)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .mul_i  (v1_q),
    .acc_i  (v2_q),
    .err_i  (err_w),
    .coef_i (coef_w),
    .ctrl_o (ctrl_o)
  );

  assign valid_o = vld_q;

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(smp_w, 3)) else $error("valid latency"); // R8
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o) else $error("valid pulse"); // R8
  AST_STROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> (!v1_q && !v2_q)) else $error("strobe spacing"); // R8 input rule
  AST_RESET_OUT: assert property (@(posedge clk_i)
    !rst_ni |-> (ctrl_o == '0 && !valid_o)) else $error("reset out"); // R9
endmodule

// File: tb/pid_incr_ctrl_tb_top.sv
`timescale 1ns/1ps
module pid_incr_ctrl_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0;
  logic strobe_i = 1'b0;
  logic signed [11:0] ref_i = '0, meas_i = '0;
  logic signed [15:0] coef_a_i = '0, coef_b_i = '0, coef_c_i = '0;
  logic signed [11:0] ctrl_o;
  logic valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  longint m_c = 0, m_e1 = 0, m_e2 = 0;

  always #2.5 clk_i = ~clk_i;

  pid_incr_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .strobe_i(strobe_i),
    .ref_i(ref_i), .meas_i(meas_i), .coef_a_i(coef_a_i), .coef_b_i(coef_b_i),
    .coef_c_i(coef_c_i), .ctrl_o(ctrl_o), .valid_o(valid_o)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint model(longint r, longint y);
    longint e, acc, q;
    e   = r - y;
    acc = m_c * 4096 + longint'(coef_a_i) * e + longint'(coef_b_i) * m_e1
        + longint'(coef_c_i) * m_e2;
    q   = acc >>> 12;
    if (q > 2047) q = 2047;
    if (q < -2048) q = -2048;
    m_e2 = m_e1;
    m_e1 = e;
    m_c  = q;
    return q;
  endfunction

  // entered at a negedge; leaves at a negedge
  task automatic sample(int r, int y, string req);
    longint exp;
    ref_i = 12'(r); meas_i = 12'(y); strobe_i = 1'b1;
    @(negedge clk_i); strobe_i = 1'b0;
    chk("R8 valid low edge N", valid_o, 0);
    @(negedge clk_i);
    chk("R8 valid low edge N+1", valid_o, 0);
    @(negedge clk_i);
    exp = model(r, y);
    chk("R8 valid high edge N+2", valid_o, 1);
    chk(req, ctrl_o, exp);
    @(negedge clk_i);
    chk("R8 valid one cycle", valid_o, 0);
  endtask

  task automatic set_coef(int a, int b, int c);
    coef_a_i = 16'(a); coef_b_i = 16'(b); coef_c_i = 16'(c);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 ctrl in reset", ctrl_o, 0);
    chk("R9 valid in reset", valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 ctrl after reset", ctrl_o, 0);
  endtask

  task automatic t_prop();
    set_coef(16'h1000, 0, 0);  // R3 1.0
    sample(100, 40, "R1 R2 p-only");
    sample(-30, 10, "R1 R2 p-only negative error");
    sample(2047, -2048, "R1 full-range error saturates R6");
  endtask

  task automatic t_clear();
    clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
    m_c = 0; m_e1 = 0; m_e2 = 0;
    chk("R7 ctrl cleared", ctrl_o, 0);
    set_coef(0, 16'h1000, 16'h1000);  // only history weighs
    sample(500, 0, "R7 history zero after clear");
    // clear together with strobe: strobe ignored
    set_coef(16'h1000, 16'h1000, 16'h1000);
    ref_i = 12'sd300; meas_i = 12'sd0; strobe_i = 1'b1; clr_i = 1'b1;
    @(negedge clk_i); strobe_i = 1'b0; clr_i = 1'b0;
    m_c = 0; m_e1 = 0; m_e2 = 0;
    repeat (3) begin
      chk("R7 strobe with clear no valid", valid_o, 0);
      @(negedge clk_i);
    end
    chk("R7 ctrl zero after clear+strobe", ctrl_o, 0);
    set_coef(0, 16'h1000, 0);
    sample(0, 0, "R7 taps untouched by dropped strobe");
  endtask

  task automatic t_pid();
    set_coef(16'h1800, 16'hE000, 16'h0800);  // R3 1.5, -2.0, 0.5
    sample(200, 0, "R2 R4 pid step 1");
    sample(150, 20, "R2 R4 pid step 2");
    sample(-80, 60, "R2 R4 pid step 3");
    sample(10, 10, "R4 pid zero error uses history");
    sample(-7, 300, "R2 pid step 5");
  endtask

  task automatic t_floor();
    clr_i = 1'b1; @(negedge clk_i); clr_i = 1'b0;
    m_c = 0; m_e1 = 0; m_e2 = 0;
    set_coef(16'h0800, 0, 0);  // 0.5
    sample(0, 3, "R2 floor -1.5 to -2");
    sample(1, 0, "R2 floor -1.5 to -2 again");
  endtask

  task automatic t_hold();
    longint held;
    held = ctrl_o;
    for (int i = 0; i < 8; i++) begin
      ref_i = 12'(i * 97); meas_i = 12'(-i * 31);
      @(negedge clk_i);
      chk("R5 hold ctrl", ctrl_o, held);
      chk("R5 hold no valid", valid_o, 0);
    end
  endtask

  task automatic t_sat();
    set_coef(16'h4000, 0, 0);  // 4.0
    sample(2047, -2048, "R6 saturate high");
    set_coef(0, 0, 0);
    sample(0, 0, "R6 stored saturated high reused");
    set_coef(16'h4000, 0, 0);
    sample(-2048, 2047, "R6 saturate low");
    set_coef(16'h1000, 0, 0);
    sample(5, 0, "R6 stored saturated low reused");
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_prop();
    t_clear();
    t_pid();
    t_hold();
    t_floor();
    t_sat();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule